// File: doc/BRIEF.md
# Receive Frame Length Limiter

This block sits in an HDLC receive path behind the flag and zero-bit removal logic. It takes a stream of frame events: an opening flag, data bytes, a closing flag and an abort. It counts every byte of the current frame, which means the address, control, information and check bytes. It compares that count against a programmable maximum length.

Bytes pass through unchanged, one cycle later, for as long as the running count stays within the limit. The first byte that would push the count past the limit marks the frame as too long. That byte and every later byte of the frame are dropped silently. The frame itself is not cut short. The block keeps counting until the closing flag or an abort arrives. Only then does it emit a single-cycle status word with the total byte count, the too-long bit and an abort bit, for the downstream buffer logic to attach to the last buffer of the frame.

Top module: `rx_len_limiter`

## Requirements
- R1: While `rst_n` is low and after it rises, `tx_byte_vld` and `st_valid` are 0 and no frame is open.
- R2: Outside an open frame, data bytes produce no output byte, and closing flags and aborts produce no status.
- R3: Inside a frame, a byte that leaves the running count at or below `max_len` appears on `tx_byte` with `tx_byte_vld` high exactly one cycle later, value unchanged.
- R4: The byte that makes the count exceed `max_len` and every later byte of the same frame are dropped. The frame remains open.
- R5: A closing flag inside a frame ends it. One cycle later `st_valid` is high for one cycle with `st_aborted`=0, `st_too_long` showing whether the limit was exceeded, and `st_len` equal to all bytes received in the frame, dropped ones included.
- R6: An abort inside a frame ends it and gives the same status as R5 but with `st_aborted`=1.
- R7: An opening flag clears the count and the too-long mark. An opening flag inside an open frame restarts counting with no status for the abandoned frame.
- R8: The count saturates at 2^(LEN_W+1)-1 instead of wrapping, and a frame that reached it reports that value and too-long.
- R9: When several strobes are high in one cycle, only the highest acts and the others are ignored. The order is abort, closing flag, opening flag, data byte.
- R10: With `max_len`=0 every byte of a frame is dropped and the frame is too long. A frame of exactly `max_len` bytes passes whole and is not too long, including at the largest limit 2^LEN_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_open | input | 1 | Opening flag seen |
| rx_byte_vld | input | 1 | `rx_byte` carries a frame byte |
| rx_byte | input | DATA_W | Received byte |
| rx_close | input | 1 | Closing flag seen |
| rx_abort | input | 1 | Abort sequence seen |
| max_len | input | LEN_W | Maximum frame length in bytes |
| tx_byte_vld | output | 1 | `tx_byte` carries a passed byte |
| tx_byte | output | DATA_W | Passed byte |
| st_valid | output | 1 | End-of-frame status strobe |
| st_too_long | output | 1 | Frame exceeded the limit |
| st_aborted | output | 1 | Frame ended by abort |
| st_len | output | LEN_W+1 | Bytes received in the frame, saturating |

## Verification
The bench builds the block with LEN_W=4 and DATA_W=8. With these values the largest limit is 15 and the counter saturates at 31. A 40-byte frame therefore drives the counter into saturation, and a 15-byte frame checks the top limit boundary, both in a few dozen cycles. Limits of zero, two, three and five cover the low boundary, the exact-fit case and restarts in mid-frame. Simultaneous strobes test the priority order.

// File: rtl/rxl_pkg.sv
// Shared types for the receive frame length limiter.
// Assumes at most one receive event acts per cycle; priority is resolved here.
package rxl_pkg;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_BYTE  = 3'd1,
        EV_OPEN  = 3'd2,
        EV_CLOSE = 3'd3,
        EV_ABORT = 3'd4
    } rx_ev_e;

    // Pick the single acting event: abort, close, open, byte.
    function automatic rx_ev_e pick_event(input logic open_i, input logic byte_i,
                                          input logic close_i, input logic abort_i);
        rx_ev_e ev;
        if (abort_i)      ev = EV_ABORT;
        else if (close_i) ev = EV_CLOSE;
        else if (open_i)  ev = EV_OPEN;
        else if (byte_i)  ev = EV_BYTE;
        else              ev = EV_NONE;
        return ev;
    endfunction

endpackage

// File: rtl/rxl_frame_track.sv
// Frame tracker: resolves strobe priority and keeps the open/closed frame state.
// Assumes strobes are single-cycle and already aligned to clk.
module rxl_frame_track
    import rxl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic open_i,
    input  logic byte_i,
    input  logic close_i,
    input  logic abort_i,
    output logic active_o,
    output logic clear_o,
    output logic incr_o,
    output logic end_o,
    output logic aborted_o
);

    rx_ev_e ev;
    logic   active_q;

    // Decode the acting event for this cycle.
    always_comb begin
        ev        = pick_event(open_i, byte_i, close_i, abort_i);
        clear_o   = (ev == EV_OPEN);
        incr_o    = (ev == EV_BYTE) && active_q;
        end_o     = ((ev == EV_CLOSE) || (ev == EV_ABORT)) && active_q;
        aborted_o = (ev == EV_ABORT);
    end

    // Track whether a frame is currently open.
    always_ff @(posedge clk) begin
        if (!rst_n)              active_q <= 1'b0;
        else if (ev == EV_OPEN)  active_q <= 1'b1;
        else if (end_o)          active_q <= 1'b0;
    end

    assign active_o = active_q;

    // R2
    idle_no_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> !end_o && !incr_o);

endmodule

// File: rtl/rxl_len_count.sv
// Saturating frame byte counter with limit comparison and sticky too-long mark.
// Assumes limit may change at any time; each byte is judged against the current value.
module rxl_len_count #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             incr_i,
    input  logic [LEN_W-1:0] limit_i,
    output logic [LEN_W:0]   cnt_o,
    output logic             over_o,
    output logic             pass_o
);

    localparam int CNT_W = LEN_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             over_q;
    logic             exceed;
    logic             past_ok;

    // Next count value, held at the ceiling instead of wrapping.
    always_comb begin
        cnt_nxt = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        exceed  = incr_i && (cnt_nxt > {1'b0, limit_i});
        pass_o  = incr_i && !over_q && !exceed;
    end

    // Count bytes of the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (incr_i)  cnt_q <= cnt_nxt;
    end

    // Remember that the limit was crossed until the next opening flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       over_q <= 1'b0;
        else if (clear_i) over_q <= 1'b0;
        else if (exceed)  over_q <= 1'b1;
    end

    // Mark the first cycle after reset so history checks start clean.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign over_o = over_q;

    // R8
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(clear_i) |-> cnt_q >= $past(cnt_q));

    // R8
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) && !clear_i |=> cnt_q == CNT_MAX);

    // R4
    over_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        over_q && !clear_i |=> over_q);

    // R7
    open_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0) && !over_q);

endmodule

// File: rtl/rxl_byte_gate.sv
// Output byte register: forwards accepted bytes one cycle after arrival.
// Assumes the accept decision is made combinationally upstream.
module rxl_byte_gate #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pass_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              vld_o,
    output logic [DATA_W-1:0] data_o
);

    // Register the valid strobe for each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= pass_i;
    end

    // Capture byte data only when a byte is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      data_o <= '0;
        else if (pass_i) data_o <= data_i;
    end

endmodule

// File: rtl/rxl_status.sv
// End-of-frame status register: one-cycle strobe with length and error bits.
// Assumes frame ends are at least two cycles apart (an opening flag lies between).
module rxl_status #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             end_i,
    input  logic             aborted_i,
    input  logic             too_long_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             valid_o,
    output logic             too_long_o,
    output logic             aborted_o,
    output logic [CNT_W-1:0] len_o
);

    // Raise the status strobe for the cycle after a frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= end_i;
    end

    // Capture the status fields at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            too_long_o <= 1'b0;
            aborted_o  <= 1'b0;
            len_o      <= '0;
        end else if (end_i) begin
            too_long_o <= too_long_i;
            aborted_o  <= aborted_i;
            len_o      <= len_i;
        end
    end

    // R5
    status_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

endmodule

// File: rtl/rx_len_limiter.sv
// Receive frame length limiter top: counts frame bytes, drops those past the
// programmed limit, and reports length and too-long status when the frame ends.
// Assumes flag and abort detection and bit destuffing are done upstream.
module rx_len_limiter #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_open,
    input  logic              rx_byte_vld,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_close,
    input  logic              rx_abort,
    input  logic [LEN_W-1:0]  max_len,
    output logic              tx_byte_vld,
    output logic [DATA_W-1:0] tx_byte,
    output logic              st_valid,
    output logic              st_too_long,
    output logic              st_aborted,
    output logic [LEN_W:0]    st_len
);

    localparam int CNT_W = LEN_W + 1;

    logic             frame_active;
    logic             frame_clear;
    logic             frame_incr;
    logic             frame_end;
    logic             end_aborted;
    logic [CNT_W-1:0] byte_cnt;
    logic             too_long;
    logic             byte_pass;

    rxl_frame_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_i    (rx_open),
        .byte_i    (rx_byte_vld),
        .close_i   (rx_close),
        .abort_i   (rx_abort),
        .active_o  (frame_active),
        .clear_o   (frame_clear),
        .incr_o    (frame_incr),
        .end_o     (frame_end),
        .aborted_o (end_aborted)
    );

    rxl_len_count #(.LEN_W(LEN_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (frame_clear),
        .incr_i  (frame_incr),
        .limit_i (max_len),
        .cnt_o   (byte_cnt),
        .over_o  (too_long),
        .pass_o  (byte_pass)
    );

    rxl_byte_gate #(.DATA_W(DATA_W)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .pass_i (byte_pass),
        .data_i (rx_byte),
        .vld_o  (tx_byte_vld),
        .data_o (tx_byte)
    );

    rxl_status #(.CNT_W(CNT_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .end_i      (frame_end),
        .aborted_i  (end_aborted),
        .too_long_i (too_long),
        .len_i      (byte_cnt),
        .valid_o    (st_valid),
        .too_long_o (st_too_long),
        .aborted_o  (st_aborted),
        .len_o      (st_len)
    );

    // R3
    tx_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_byte_vld |-> $past(frame_active) && $past(rx_byte_vld));

    // R4
    tx_not_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_byte_vld |-> !too_long);

    // R2
    status_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> $past(frame_active) && !frame_active);

endmodule

// File: tb/test_rx_len_limiter.sv
module test_rx_len_limiter;

    localparam int DATA_W = 8;
    localparam int LEN_W  = 4;
    localparam int CNT_W  = LEN_W + 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              rx_open, rx_byte_vld, rx_close, rx_abort;
    logic [DATA_W-1:0] rx_byte;
    logic [LEN_W-1:0]  max_len;
    logic              tx_byte_vld;
    logic [DATA_W-1:0] tx_byte;
    logic              st_valid, st_too_long, st_aborted;
    logic [CNT_W-1:0]  st_len;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rx_len_limiter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_rx_len_limiter (
        .clk(clk), .rst_n(rst_n), .rx_open(rx_open), .rx_byte_vld(rx_byte_vld),
        .rx_byte(rx_byte), .rx_close(rx_close), .rx_abort(rx_abort),
        .max_len(max_len), .tx_byte_vld(tx_byte_vld), .tx_byte(tx_byte),
        .st_valid(st_valid), .st_too_long(st_too_long), .st_aborted(st_aborted),
        .st_len(st_len)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of strobes from a falling edge; return after the next falling edge.
    task automatic step(input bit o, input bit bv, input logic [7:0] b, input bit c, input bit a);
        rx_open = o; rx_byte_vld = bv; rx_byte = b; rx_close = c; rx_abort = a;
        @(negedge clk);
        rx_open = 0; rx_byte_vld = 0; rx_close = 0; rx_abort = 0;
    endtask

    task automatic byte_exp(input logic [7:0] b, input bit pass, input string req);
        step(0, 1, b, 0, 0);
        chk(tx_byte_vld == pass, req, tx_byte_vld, pass);
        if (pass) chk(tx_byte == b, req, tx_byte, b);
        chk(!st_valid, req, st_valid, 0);
    endtask

    task automatic end_exp(input bit abort, input bit too_long, input int len, input string req);
        step(0, 0, 8'h00, !abort, abort);
        chk(st_valid == 1'b1, req, st_valid, 1);
        chk(st_aborted == abort, req, st_aborted, abort);
        chk(st_too_long == too_long, req, st_too_long, too_long);
        chk(st_len == len, req, st_len, len);
        @(negedge clk);
        chk(!st_valid, req, st_valid, 0);
    endtask

    task automatic t_reset();
        rst_n = 0; max_len = 4'd5;
        rx_open = 0; rx_byte_vld = 0; rx_byte = 0; rx_close = 0; rx_abort = 0;
        repeat (4) @(negedge clk);
        chk(!tx_byte_vld && !st_valid, "R1 in reset", {tx_byte_vld, st_valid}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!tx_byte_vld && !st_valid, "R1 after reset", {tx_byte_vld, st_valid}, 0);
    endtask

    task automatic t_idle();
        byte_exp(8'h11, 0, "R2 idle byte");
        step(0, 0, 8'h00, 1, 0);
        chk(!st_valid, "R2 idle close", st_valid, 0);
        step(0, 0, 8'h00, 0, 1);
        chk(!st_valid, "R2 idle abort", st_valid, 0);
    endtask

    task automatic t_normal();
        max_len = 4'd5;
        step(1, 0, 8'h00, 0, 0);
        byte_exp(8'hA5, 1, "R3 byte1");
        byte_exp(8'h3C, 1, "R3 byte2");
        byte_exp(8'hFF, 1, "R3 byte3");
        end_exp(0, 0, 3, "R5 normal close");
    endtask

    task automatic t_long();
        max_len = 4'd3;
        step(1, 0, 8'h00, 0, 0);
        for (int i = 0; i < 6; i++) byte_exp(8'h40 + 8'(i), i < 3, "R4 long frame");
        end_exp(0, 1, 6, "R5 long close");
    endtask

    task automatic t_abort();
        max_len = 4'd2;
        step(1, 0, 8'h00, 0, 0);
        byte_exp(8'h01, 1, "R6 pre-abort");
        end_exp(1, 0, 1, "R6 abort short");
        step(1, 0, 8'h00, 0, 0);
        for (int i = 0; i < 4; i++) byte_exp(8'h20 + 8'(i), i < 2, "R6 pre-abort long");
        end_exp(1, 1, 4, "R6 abort long");
    endtask

    task automatic t_restart();
        max_len = 4'd2;
        step(1, 0, 8'h00, 0, 0);
        for (int i = 0; i < 4; i++) byte_exp(8'h70 + 8'(i), i < 2, "R7 first part");
        step(1, 0, 8'h00, 0, 0);
        chk(!st_valid, "R7 restart no status", st_valid, 0);
        byte_exp(8'h81, 1, "R7 after restart");
        byte_exp(8'h82, 1, "R7 after restart");
        end_exp(0, 0, 2, "R7 restart close");
    endtask

    task automatic t_saturate();
        max_len = 4'd15;
        step(1, 0, 8'h00, 0, 0);
        for (int i = 0; i < 40; i++) byte_exp(8'(i), i < 15, "R8 sat frame");
        end_exp(0, 1, 31, "R8 saturated length");
    endtask

    task automatic t_priority();
        max_len = 4'd5;
        step(1, 1, 8'h99, 0, 0);
        chk(!tx_byte_vld, "R9 open beats byte", tx_byte_vld, 0);
        byte_exp(8'h12, 1, "R9 frame open");
        step(0, 1, 8'h34, 1, 0);
        chk(st_valid && !st_aborted && st_len == 1, "R9 close beats byte", st_len, 1);
        chk(!tx_byte_vld, "R9 close beats byte tx", tx_byte_vld, 0);
        step(1, 0, 8'h00, 0, 0);
        byte_exp(8'h56, 1, "R9 frame open 2");
        step(1, 1, 8'h00, 1, 1);
        chk(st_valid && st_aborted && st_len == 1, "R9 abort beats all", st_aborted, 1);
        step(1, 0, 8'h00, 0, 1);
        chk(!st_valid, "R9 idle abort beats open", st_valid, 0);
        byte_exp(8'h77, 0, "R9 open ignored");
    endtask

    task automatic t_bounds();
        max_len = 4'd0;
        step(1, 0, 8'h00, 0, 0);
        byte_exp(8'hE1, 0, "R10 zero limit");
        end_exp(0, 1, 1, "R10 zero limit close");
        max_len = 4'd15;
        step(1, 0, 8'h00, 0, 0);
        for (int i = 0; i < 15; i++) byte_exp(8'hC0 + 8'(i), 1, "R10 exact max");
        end_exp(0, 0, 15, "R10 exact max close");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_idle();
        t_normal();
        t_long();
        t_abort();
        t_restart();
        t_saturate();
        t_priority();
        t_bounds();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule